// File: doc/BRIEF.md
# Breadth-First State Space Explorer

This block walks the reachable states of a small finite model, one state at a time, without software in the loop. A state is one fixed-width vector that holds the program counter and every variable of the model. Software hands the block a starting vector and a start pulse. The block keeps a FIFO of frontier states that still wait to be expanded and a direct-mapped table of states it has already met. It takes each frontier state off the queue and offers it to an external successor generator. It then takes the generator's answers back as a stream of beats, one per clock. Each beat carries a candidate successor, the verdict of the model's assertion predicate and an end-of-list mark.

Each candidate is looked up in the seen-state table. A state found there is dropped. A new state is written into the table and appended to the frontier, and it is also pushed out on a valid/ready violation port when the predicate flagged it. A stall on that port holds the whole loop. The run stops by itself once the frontier is empty and no candidate is still in the pipeline. It also stops, with a sticky error, when a new state finds the frontier full.

The seen-state table is indexed by a bit-fold hash of the vector and holds full vectors, so a hit is always exact. A collision simply replaces the older entry. Such a state may be met and expanded again later. That costs time but never loses a state.

Top module: `bfs_explore_core`

## Requirements
- R1: After reset, `busy`, `done`, `overflow`, `gen_req_valid`, `viol_valid` and `succ_ready` are all 0.
- R2: A `start` pulse is taken only while `busy` is 0. Taking it clears `done`, `overflow`, the frontier and the seen-state table, and raises `busy` on the next cycle. A `start` pulse seen while `busy` is 1 has no effect on the run.
- R3: Frontier states are offered on `gen_req_state` in strict FIFO order, the start state first. A request stays valid with a stable vector until `gen_req_ready` is 1.
- R4: After a request handshake, the core takes successor beats on `succ_valid`/`succ_ready` until it takes a beat with `succ_last` = 1. A beat with `succ_keep` = 0 carries no state, which is how a state with no successors is reported. Every kept beat is examined.
- R5: The table index is the fold of the vector: bit i of the state is XORed into index bit (i mod HW). A kept successor counts as seen only if the slot holds that exact vector. Otherwise the successor is new and overwrites the slot. The start state is entered into the table before exploring, so it counts as seen.
- R6: A new successor whose `succ_viol` is 1 appears once on `viol_state`, in the order of discovery. Successors already seen are never logged, and neither is the start state.
- R7: While `viol_valid` is 1 and `viol_ready` is 0, the entry stays on the port unchanged. A further violating state then stalls the loop, so no entry is lost.
- R8: A new successor that finds QDEPTH states in the frontier raises `overflow`. That successor is neither logged nor stored, and the core stops accepting beats and issuing requests. `overflow` stays 1 until the next accepted `start`.
- R9: `done` rises when the frontier is empty and no successor is pending. It stays 1, with `busy` = 0, until the next accepted `start`. It is never 1 together with `overflow`.
- R10: While the violation port is not stalled, the core takes one successor beat on every cycle in which `succ_valid` is 1 during the reply stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_state | input | SW | Start vector, captured with `start` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with the frontier empty |
| overflow | output | 1 | Sticky error: frontier full on a new state |
| gen_req_valid | output | 1 | Frontier state offered to the generator |
| gen_req_ready | input | 1 | Generator takes the offered state |
| gen_req_state | output | SW | Vector of the offered state |
| succ_valid | input | 1 | Successor beat present |
| succ_ready | output | 1 | Core takes the beat this cycle |
| succ_state | input | SW | Successor vector |
| succ_keep | input | 1 | Beat carries a real successor |
| succ_last | input | 1 | Final beat for the current parent |
| succ_viol | input | 1 | Assertion predicate failed for this successor |
| viol_valid | output | 1 | Violating state on the log port |
| viol_ready | input | 1 | Log sink takes the entry |
| viol_state | output | SW | Violating vector |

## Verification
The hardest case to reach from the ports is a run of colliding vectors arriving back to back. Here a successor must see the table slot written by the one just before it, on the very cycle that write happens, while the log port may stall in between. The stimulus reaches this with a generator stub whose successor function, predicate and handshake behaviour are drawn at random for each run. A bench model of the frontier and the folded table predicts the exact order of requests and log entries, including re-exploration after collisions. Runs are kept only where the model terminates, and are then chosen to end in completion or in a full frontier. Directed runs add a childless start state, an ignored mid-run start and a stall-free stream for throughput.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SEED,
    ST_FETCH,
    ST_REQ,
    ST_SUCC,
    ST_DONE,
    ST_HALT
  } core_st_t;

endpackage

// File: rtl/bfs_fold_hash.sv
module bfs_fold_hash #(
  parameter int SW = 8,
  parameter int HW = 6
) (
  input  logic [SW-1:0] vec,
  output logic [HW-1:0] idx
);

  // bit i of the vector lands in index bit (i mod HW)
  always_comb begin
    idx = '0;
    for (int i = 0; i < SW; i++) begin
      idx[i % HW] = idx[i % HW] ^ vec[i];
    end
  end

endmodule

// File: rtl/bfs_work_fifo.sv
module bfs_work_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CNT_MAX = AW'(DEPTH - 1) + 1'b1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) bump = '0;
    else                     bump = p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full)  wr_ptr <= bump(wr_ptr);
      if (pop && !empty)  rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/bfs_seen_table.sv
module bfs_seen_table #(
  parameter int SW = 8,
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [HW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [SW-1:0] rd_state,
  input  logic          wr_en,
  input  logic [HW-1:0] wr_idx,
  input  logic          wr_valid,
  input  logic [SW-1:0] wr_state
);

  localparam int DEPTH = 1 << HW;

  logic [SW:0] mem [DEPTH];
  logic [SW:0] ram_q;
  logic [SW:0] fwd_word;
  logic        fwd_hit;

  // plain synchronous-read memory, block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_valid, wr_state};
    if (rd_en) ram_q <= mem[rd_idx];
  end

  // a write to the slot being read on the same edge wins over the old word
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_word <= '0;
    end else if (rd_en) begin
      fwd_hit  <= wr_en && (wr_idx == rd_idx);
      fwd_word <= {wr_valid, wr_state};
    end
  end

  assign rd_valid = fwd_hit ? fwd_word[SW]     : ram_q[SW];
  assign rd_state = fwd_hit ? fwd_word[SW-1:0] : ram_q[SW-1:0];

endmodule

// File: rtl/bfs_explore_core.sv
module bfs_explore_core
  import bfs_pkg::*;
#(
  parameter int SW     = 8,
  parameter int QDEPTH = 16,
  parameter int HW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] start_state,
  output logic          busy,
  output logic          done,
  output logic          overflow,
  output logic          gen_req_valid,
  input  logic          gen_req_ready,
  output logic [SW-1:0] gen_req_state,
  input  logic          succ_valid,
  output logic          succ_ready,
  input  logic [SW-1:0] succ_state,
  input  logic          succ_keep,
  input  logic          succ_last,
  input  logic          succ_viol,
  output logic          viol_valid,
  input  logic          viol_ready,
  output logic [SW-1:0] viol_state
);

  localparam logic [HW-1:0] LAST_SLOT = '1;

  core_st_t      st;
  logic [SW-1:0] seed_r;
  logic [HW-1:0] clr_idx;

  logic          s1_valid, s1_viol, last_seen;
  logic [SW-1:0] s1_state;
  logic [HW-1:0] s1_idx;

  logic [HW-1:0] succ_idx, seed_idx;
  logic          tb_valid;
  logic [SW-1:0] tb_state;

  logic          tb_wr_en, tb_wr_valid;
  logic [HW-1:0] tb_wr_idx;
  logic [SW-1:0] tb_wr_state;

  logic          q_push, q_pop, q_full, q_empty;
  logic [SW-1:0] q_push_data, q_head;

  logic idle_st, start_ok, s1_new, ovf_hit, log_free, s1_fire, acc;

  bfs_fold_hash #(.SW(SW), .HW(HW)) u_hash_succ (.vec(succ_state), .idx(succ_idx));
  bfs_fold_hash #(.SW(SW), .HW(HW)) u_hash_seed (.vec(seed_r),     .idx(seed_idx));

  bfs_seen_table #(.SW(SW), .HW(HW)) u_seen (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (acc && succ_keep),
    .rd_idx   (succ_idx),
    .rd_valid (tb_valid),
    .rd_state (tb_state),
    .wr_en    (tb_wr_en),
    .wr_idx   (tb_wr_idx),
    .wr_valid (tb_wr_valid),
    .wr_state (tb_wr_state)
  );

  bfs_work_fifo #(.W(SW), .DEPTH(QDEPTH)) u_frontier (
    .clk       (clk),
    .rst       (rst),
    .flush     (start_ok),
    .push      (q_push),
    .push_data (q_push_data),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign idle_st  = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_HALT);
  assign busy     = !idle_st;
  assign start_ok = start && idle_st;

  // stage 1: compare against the table word read on the accepting edge
  assign s1_new   = !(tb_valid && (tb_state == s1_state));
  assign ovf_hit  = s1_valid && s1_new && q_full;
  assign log_free = !viol_valid || viol_ready;
  assign s1_fire  = s1_valid && !ovf_hit && (!s1_new || !s1_viol || log_free);

  assign succ_ready = (st == ST_SUCC) && !last_seen && (!s1_valid || s1_fire);
  assign acc        = succ_valid && succ_ready;

  assign q_push      = (st == ST_SEED) || (s1_fire && s1_new);
  assign q_push_data = (st == ST_SEED) ? seed_r : s1_state;
  assign q_pop       = (st == ST_FETCH) && !q_empty;

  always_comb begin
    case (st)
      ST_CLEAR: begin
        tb_wr_en    = 1'b1;
        tb_wr_idx   = clr_idx;
        tb_wr_valid = 1'b0;
        tb_wr_state = '0;
      end
      ST_SEED: begin
        tb_wr_en    = 1'b1;
        tb_wr_idx   = seed_idx;
        tb_wr_valid = 1'b1;
        tb_wr_state = seed_r;
      end
      default: begin
        tb_wr_en    = s1_fire && s1_new;
        tb_wr_idx   = s1_idx;
        tb_wr_valid = 1'b1;
        tb_wr_state = s1_state;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      seed_r        <= '0;
      clr_idx       <= '0;
      s1_valid      <= 1'b0;
      s1_viol       <= 1'b0;
      s1_state      <= '0;
      s1_idx        <= '0;
      last_seen     <= 1'b0;
      done          <= 1'b0;
      overflow      <= 1'b0;
      gen_req_valid <= 1'b0;
      gen_req_state <= '0;
      viol_valid    <= 1'b0;
      viol_state    <= '0;
    end else begin
      if (viol_valid && viol_ready) viol_valid <= 1'b0;
      if (s1_fire && s1_new && s1_viol) begin
        viol_valid <= 1'b1;
        viol_state <= s1_state;
      end
      if (s1_fire) s1_valid <= 1'b0;
      if (acc && succ_keep) begin
        s1_valid <= 1'b1;
        s1_state <= succ_state;
        s1_viol  <= succ_viol;
        s1_idx   <= succ_idx;
      end
      if (acc && succ_last) last_seen <= 1'b1;

      case (st)
        ST_IDLE, ST_DONE, ST_HALT: begin
          if (start) begin
            seed_r   <= start_state;
            clr_idx  <= '0;
            done     <= 1'b0;
            overflow <= 1'b0;
            st       <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST_SLOT) st <= ST_SEED;
        end
        ST_SEED: st <= ST_FETCH;
        ST_FETCH: begin
          if (q_empty) begin
            done <= 1'b1;
            st   <= ST_DONE;
          end else begin
            gen_req_valid <= 1'b1;
            gen_req_state <= q_head;
            st            <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (gen_req_ready) begin
            gen_req_valid <= 1'b0;
            last_seen     <= 1'b0;
            st            <= ST_SUCC;
          end
        end
        ST_SUCC: begin
          if (ovf_hit) begin
            overflow <= 1'b1;
            s1_valid <= 1'b0;
            st       <= ST_HALT;
          end else if (last_seen && !s1_valid) begin
            st <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bfs_explore_checker.sv
module bfs_explore_checker #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          overflow,
  input logic          gen_req_valid,
  input logic          gen_req_ready,
  input logic [SW-1:0] gen_req_state,
  input logic          succ_ready,
  input logic          viol_valid,
  input logic          viol_ready,
  input logic [SW-1:0] viol_state
);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done && !overflow));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (gen_req_valid && !gen_req_ready) |=> (gen_req_valid && $stable(gen_req_state)));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!succ_ready && !gen_req_valid));

  assert_log_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && !viol_ready) |=> (viol_valid && $stable(viol_state)));

  assert_no_overflow_release_R8: assert property (@(posedge clk) disable iff (rst)
    (overflow && !start) |=> overflow);

  assert_halted_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (!succ_ready && !gen_req_valid && !busy));

  assert_done_alone_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !overflow));

endmodule

bind bfs_explore_core bfs_explore_checker #(.SW(SW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .overflow      (overflow),
  .gen_req_valid (gen_req_valid),
  .gen_req_ready (gen_req_ready),
  .gen_req_state (gen_req_state),
  .succ_ready    (succ_ready),
  .viol_valid    (viol_valid),
  .viol_ready    (viol_ready),
  .viol_state    (viol_state)
);

// File: tb/sim_bfs_explore_core.sv
module sim_bfs_explore_core;

  localparam int SW = 8;
  localparam int QD = 16;
  localparam int HW = 6;
  localparam int TS = 1 << HW;
  localparam int MAXN = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SW-1:0] start_state = '0;
  logic busy, done, overflow;
  logic gen_req_valid, gen_req_ready;
  logic [SW-1:0] gen_req_state;
  logic succ_valid, succ_ready, succ_keep, succ_last, succ_viol;
  logic [SW-1:0] succ_state;
  logic viol_valid, viol_ready;
  logic [SW-1:0] viol_state;

  always #10 clk = ~clk;

  bfs_explore_core #(.SW(SW), .QDEPTH(QD), .HW(HW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_state(start_state),
    .busy(busy), .done(done), .overflow(overflow),
    .gen_req_valid(gen_req_valid), .gen_req_ready(gen_req_ready),
    .gen_req_state(gen_req_state),
    .succ_valid(succ_valid), .succ_ready(succ_ready), .succ_state(succ_state),
    .succ_keep(succ_keep), .succ_last(succ_last), .succ_viol(succ_viol),
    .viol_valid(viol_valid), .viol_ready(viol_ready), .viol_state(viol_state)
  );

  int checks = 0;
  int errors = 0;

  // model configuration of the stub graph
  int cfg_fmax, cfg_mul, cfg_step, cfg_add, cfg_mul2, cfg_salt, cfg_vsalt, cfg_vmask;
  bit fast_mode = 1'b0;

  // expected results
  int m_np, m_nl;
  bit m_ovf, m_runaway;
  logic [SW-1:0] m_par [MAXN];
  logic [SW-1:0] m_log [MAXN];
  // observed results
  int g_np, g_nl, stalls;
  logic [SW-1:0] g_par [MAXN];
  logic [SW-1:0] g_log [MAXN];

  function automatic int nsucc(input logic [SW-1:0] p);
    int v;
    v = ((int'(p) * cfg_mul2 + cfg_salt) & 255) >> 2;
    return v % (cfg_fmax + 1);
  endfunction

  function automatic logic [SW-1:0] succ_of(input logic [SW-1:0] p, input int i);
    return SW'((int'(p) * cfg_mul + i * cfg_step + cfg_add) & 255);
  endfunction

  function automatic bit is_bad(input logic [SW-1:0] s);
    return ((int'(s) ^ cfg_vsalt) & cfg_vmask) == 0;
  endfunction

  function automatic int fold(input logic [SW-1:0] s);
    int h = 0;
    for (int i = 0; i < SW; i++) if (s[i]) h = h ^ (1 << (i % HW));
    return h;
  endfunction

  task automatic model_run(input logic [SW-1:0] s0);
    bit tv [TS];
    logic [SW-1:0] tsv [TS];
    logic [SW-1:0] q [QD];
    int qh, qt, qc, n, h;
    logic [SW-1:0] p, s;
    for (int k = 0; k < TS; k++) begin tv[k] = 0; tsv[k] = '0; end
    m_np = 0; m_nl = 0; m_ovf = 0; m_runaway = 0;
    qh = 0; qt = 0; qc = 0;
    h = fold(s0); tv[h] = 1; tsv[h] = s0;
    q[qt] = s0; qt = (qt + 1) % QD; qc = 1;
    while (qc > 0 && !m_ovf) begin
      if (m_np >= 900) begin m_runaway = 1; break; end
      p = q[qh]; qh = (qh + 1) % QD; qc--;
      m_par[m_np] = p; m_np++;
      n = nsucc(p);
      for (int i = 0; i < n; i++) begin
        s = succ_of(p, i);
        h = fold(s);
        if (tv[h] && tsv[h] == s) continue;
        if (qc == QD) begin m_ovf = 1; break; end
        tv[h] = 1; tsv[h] = s;
        if (is_bad(s) && m_nl < MAXN) begin m_log[m_nl] = s; m_nl++; end
        q[qt] = s; qt = (qt + 1) % QD; qc++;
      end
    end
  endtask

  // generator stub and log sink, driven between clock edges
  bit pend = 0, f_req = 0, f_succ = 0;
  logic [SW-1:0] sp = '0;
  int sn = 0, si = 0;

  initial begin
    gen_req_ready = 0; succ_valid = 0; succ_state = '0; succ_keep = 0;
    succ_last = 0; succ_viol = 0; viol_ready = 0;
    forever begin
      @(negedge clk);
      if (f_succ) begin
        if (succ_last) pend = 0; else si++;
      end
      if (f_req) begin
        pend = 1; sp = gen_req_state; sn = nsucc(gen_req_state); si = 0;
      end
      if (overflow || rst) pend = 0;
      if (!pend) succ_valid = 0;
      else if (succ_valid && !f_succ) succ_valid = 1;
      else succ_valid = fast_mode ? 1'b1 : ($urandom % 3 != 0);
      if (sn == 0) begin
        succ_keep = 0; succ_last = 1; succ_state = '0; succ_viol = 0;
      end else begin
        succ_keep = 1; succ_last = (si == sn - 1);
        succ_state = succ_of(sp, si); succ_viol = is_bad(succ_state);
      end
      gen_req_ready = fast_mode ? 1'b1 : ($urandom % 2 == 0);
      viol_ready    = fast_mode ? 1'b1 : ($urandom % 3 != 0);
      #1;
      f_req  = gen_req_valid && gen_req_ready;
      f_succ = succ_valid && succ_ready;
      if (f_req && g_np < MAXN) begin g_par[g_np] = gen_req_state; g_np++; end
      if (viol_valid && viol_ready && g_nl < MAXN) begin g_log[g_nl] = viol_state; g_nl++; end
      if (pend && succ_valid && !succ_ready && busy) stalls++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pick_cfg(input int fmax, input int want_ovf, input int min_par, output logic [SW-1:0] s0);
    for (int t = 0; t < 400; t++) begin
      cfg_fmax = fmax;
      cfg_mul = ($urandom % 128) * 2 + 1; cfg_step = ($urandom % 128) * 2 + 1;
      cfg_add = $urandom % 256; cfg_mul2 = $urandom % 256; cfg_salt = $urandom % 256;
      cfg_vsalt = $urandom % 256;
      case ($urandom % 3) 0: cfg_vmask = 3; 1: cfg_vmask = 5; default: cfg_vmask = 7; endcase
      s0 = SW'($urandom % 256);
      model_run(s0);
      if (!m_runaway && m_np >= min_par && (want_ovf == 2 || int'(m_ovf) == want_ovf)) return;
    end
    $display("note: configuration search fell back");
  endtask

  task automatic run_case(input string tag, input logic [SW-1:0] s0, input bit fast, input bit inject);
    int w;
    fast_mode = fast;
    model_run(s0);
    g_np = 0; g_nl = 0; stalls = 0;
    @(negedge clk); start = 1; start_state = s0;
    @(negedge clk); start = 0; start_state = ~s0;
    check(busy === 1'b1 && done === 1'b0 && overflow === 1'b0, "R2", {tag, " start taken"}, int'(busy), 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      check(busy === 1'b1, "R2", {tag, " busy before extra start"}, int'(busy), 1);
      start = 1;
      @(negedge clk); start = 0;
    end
    w = 0;
    while (!(done || overflow) && w < 40000) begin @(negedge clk); w++; end
    w = 0;
    while (viol_valid && w < 400) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    check(overflow === m_ovf, "R8", {tag, " overflow flag"}, int'(overflow), int'(m_ovf));
    check(done === !m_ovf && busy === 1'b0, "R9", {tag, " done flag"}, int'(done), int'(!m_ovf));
    begin
      int bad = -1;
      for (int k = 0; k < m_np && k < g_np; k++) if (bad < 0 && g_par[k] !== m_par[k]) bad = k;
      check(g_np == m_np, "R3", {tag, " request count (R4 R5)"}, g_np, m_np);
      check(bad < 0, "R5", {tag, " request order, first mismatch index"}, bad, -1);
    end
    begin
      int bad = -1;
      for (int k = 0; k < m_nl && k < g_nl; k++) if (bad < 0 && g_log[k] !== m_log[k]) bad = k;
      check(g_nl == m_nl, "R6", {tag, " log count (R7)"}, g_nl, m_nl);
      check(bad < 0, "R7", {tag, " log order, first mismatch index"}, bad, -1);
    end
    if (fast && !m_ovf) check(stalls == 0, "R10", {tag, " stalled beats"}, stalls, 0);
    if (m_ovf) begin
      repeat (6) @(negedge clk);
      check(overflow === 1'b1 && !gen_req_valid && !succ_ready, "R8", {tag, " sticky halt"}, int'(overflow), 1);
    end
  endtask

  // watchdog
  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [SW-1:0] s0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !overflow && !gen_req_valid && !viol_valid && !succ_ready,
          "R1", "outputs after reset", int'({busy, done, overflow, gen_req_valid, viol_valid, succ_ready}), 0);

    // R4: childless start state, one empty beat only
    cfg_fmax = 0; cfg_mul = 1; cfg_step = 1; cfg_add = 0; cfg_mul2 = 0; cfg_salt = 0;
    cfg_vsalt = 0; cfg_vmask = 7;
    run_case("childless", 8'h5A, 1'b0, 1'b0);

    // R10: stall-free stream, no overflow
    pick_cfg(2, 0, 6, s0);
    run_case("throughput", s0, 1'b1, 1'b0);

    // R8: frontier fills up
    pick_cfg(3, 1, 2, s0);
    run_case("overflow", s0, 1'b0, 1'b0);

    // R2: restart after overflow, and an extra start during a run
    pick_cfg(2, 0, 4, s0);
    run_case("ignored start", s0, 1'b0, 1'b1);

    for (int r = 0; r < 8; r++) begin
      pick_cfg(1 + ($urandom % 3), 2, 3, s0);
      run_case($sformatf("random %0d", r), s0, (r % 3 == 0), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule